// File: doc/BRIEF.md
# PS/2 Host Port with Interrupt Register Bank

This block is a single PS/2 host port reached through a small byte-wide register bank of eight locations. Software starts a transmission to the attached device by writing one byte to the transmit location; the port then holds the clock line low for an inhibit period, requests to send, and shifts the byte out on the clock edges the device generates. Frames arriving from the device are shifted in on filtered falling clock edges, checked, and placed in a receive location.

Four event bits record transmit completion, transmit failure, receive data ready and receive failure. Software may poll them, or unmask them so that they drive a level interrupt output. Each event can be set or cleared by software and masked on its own. Both PS/2 lines are driven only through active-high pull-down enables meant for external open-collector drivers, and are sampled through separate inputs that pass a two-flop synchronizer and a glitch filter.

Top module: `ps2_host_port`

## Requirements
- R1: After reset both pull-down outputs are low, the event bits read 0, the mask location reads 0x0F (all events masked) and the interrupt output is low.
- R2: A write to address 0 holds the clock pull-down high for at least INHIBIT_CYC cycles, raises the data pull-down while the clock is still held, then releases the clock with the data line still low (start bit).
- R3: On the device's clock the port presents the 8 data bits LSB first, then an odd-parity bit, then a stop bit of 1 (data released).
- R4: An acknowledge of 0 on the data line at the device's eleventh falling clock edge sets event bit 0 (transmit done); a 1 there sets event bit 1 (transmit error) instead.
- R5: If a transmission has not finished TIMEOUT_CYC cycles after the clock was released, event bit 1 is set and the port returns to idle with the busy bit (status bit 4) clear.
- R6: While a transmission is in progress, status bit 4 reads 1 and a write to address 0 is ignored: the byte read back from address 0 and the byte sent stay those of the first write.
- R7: A frame from the device with start 0, correct odd parity and stop 1 places its byte at address 1 and sets event bit 2 (receive ready).
- R8: A received frame with wrong parity or a stop bit of 0 sets event bit 3 (receive error), leaves event bit 2 clear and leaves address 1 unchanged.
- R9: A received frame that does not complete within TIMEOUT_CYC cycles of its start bit sets event bit 3.
- R10: Address 2 reads the event bits in [3:0] and busy in [4]; writing ones to address 3 sets and to address 4 clears the matching event bits; address 5 holds the mask, where a 1 masks that event.
- R11: The interrupt output is high exactly when some event bit is set and unmasked; address 6 reads the unmasked pending events.
- R12: Pulses on the clock input shorter than FILT_LEN cycles are not treated as edges and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_en | input | 1 | Register read enable; read data is zero when low |
| reg_rd_data | output | 8 | Register read data (combinational) |
| ps2_clk_in | input | 1 | Sampled PS/2 clock line |
| ps2_data_in | input | 1 | Sampled PS/2 data line |
| ps2_clk_pd | output | 1 | High pulls the PS/2 clock line low |
| ps2_data_pd | output | 1 | High pulls the PS/2 data line low |
| irq | output | 1 | Level interrupt, high when an unmasked event is set |

## Verification
A wrong bit counter or shift register in either state machine shows within one frame: the device model captures a wrong byte, parity or stop bit, or an event bit lands in the wrong position when status is read a half clock period after the last edge. A stuck transmit state shows as a clock pull-down held past the inhibit period or a busy bit that never clears, caught by the timeout check within TIMEOUT_CYC cycles. Errors in the event register or mask logic appear on the interrupt pin in the cycle after the offending register write.

// File: rtl/ps2_pkg.sv
// Shared constants and state types for the PS/2 host port.
// Assumes a byte-wide register bank of eight locations.
package ps2_pkg;
    localparam int BYTE_W  = 8;
    localparam int REG_CNT = 8;
    localparam int ADDR_W  = $clog2(REG_CNT);
    localparam int FRAME_W = 10;  // bits following the start bit
    localparam int EV_W    = 4;

    localparam logic [ADDR_W-1:0] A_TXD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_RXD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_SET  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd5;
    localparam logic [ADDR_W-1:0] A_PEND = 3'd6;

    typedef enum logic [2:0] {
        TX_IDLE, TX_INHIBIT, TX_REQ, TX_SHIFT, TX_ACK
    } tx_state_e;

    typedef enum logic {
        RX_IDLE, RX_SHIFT
    } rx_state_e;
endpackage

// File: rtl/ps2_line_filter.sv
// Two-flop synchronizer followed by a persistence filter.
// The clean output follows the input only after it has differed for
// FILT_LEN consecutive cycles. Idle level of the line is high.
module ps2_line_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_in};
    end

    // Accept a new level only once it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= '0;
            line_clean <= 1'b1;
        end else if (sync_q[1] == line_clean) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            run_q      <= '0;
            line_clean <= sync_q[1];
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps2_rx_fsm.sv
// Receive state machine: shifts in a device frame on filtered falling
// clock edges, checks odd parity and stop bit, and bounds the frame
// length with a timeout. Assumes edges arrive as one-cycle pulses.
module ps2_rx_fsm
    import ps2_pkg::*;
#(
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              bit_fall,
    input  logic              bit_val,
    output logic              rx_done,
    output logic              rx_err,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    rx_state_e          state_q;
    logic [3:0]         idx_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [TW-1:0]      timer_q;
    logic [FRAME_W-1:0] frame_next;
    logic               frame_ok;

    assign frame_next = {bit_val, shreg_q[FRAME_W-1:1]};
    assign frame_ok   = (^frame_next[BYTE_W:0]) && frame_next[FRAME_W-1];

    // Frame sequencing, checking and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
            timer_q <= '0;
            rx_done <= 1'b0;
            rx_err  <= 1'b0;
            rx_byte <= '0;
        end else begin
            rx_done <= 1'b0;
            rx_err  <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    timer_q <= '0;
                    idx_q   <= '0;
                    if (rx_enable && bit_fall && !bit_val) state_q <= RX_SHIFT;
                end
                RX_SHIFT: begin
                    if (!rx_enable) begin
                        state_q <= RX_IDLE;
                    end else if (timer_q == TW'(TIMEOUT_CYC - 1)) begin
                        rx_err  <= 1'b1;
                        state_q <= RX_IDLE;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                        if (bit_fall) begin
                            shreg_q <= frame_next;
                            idx_q   <= idx_q + 1'b1;
                            if (idx_q == 4'(FRAME_W - 1)) begin
                                state_q <= RX_IDLE;
                                if (frame_ok) begin
                                    rx_done <= 1'b1;
                                    rx_byte <= frame_next[BYTE_W-1:0];
                                end else begin
                                    rx_err <= 1'b1;
                                end
                            end
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ps2_tx_fsm.sv
// Transmit state machine: inhibits the bus, requests to send, shifts
// data/parity/stop on device falling edges and samples the acknowledge.
// Assumes the device clock is seen as filtered one-cycle fall pulses.
module ps2_tx_fsm
    import ps2_pkg::*;
#(
    parameter int INHIBIT_CYC = 25000,
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              bit_fall,
    input  logic              bit_val,
    output logic              tx_busy,
    output logic              clk_pd,
    output logic              data_pd,
    output logic              tx_done,
    output logic              tx_err
);
    localparam int CMAX = (INHIBIT_CYC > TIMEOUT_CYC) ? INHIBIT_CYC : TIMEOUT_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    tx_state_e          state_q;
    logic [FRAME_W-1:0] frame_q;
    logic [3:0]         idx_q;
    logic               dbit_q;
    logic [CW-1:0]      cnt_q;
    logic               timed_out;

    assign timed_out = (cnt_q == CW'(TIMEOUT_CYC - 1));

    // Line drive decoded from the current phase.
    always_comb begin
        clk_pd  = (state_q == TX_INHIBIT) || (state_q == TX_REQ);
        data_pd = (state_q == TX_REQ) || ((state_q == TX_SHIFT) && !dbit_q);
        tx_busy = (state_q != TX_IDLE);
    end

    // Transmit sequencing, bit shifting, acknowledge and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            frame_q <= '0;
            idx_q   <= '0;
            dbit_q  <= 1'b1;
            cnt_q   <= '0;
            tx_done <= 1'b0;
            tx_err  <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            tx_err  <= 1'b0;
            case (state_q)
                TX_IDLE: begin
                    cnt_q <= '0;
                    if (tx_start) begin
                        frame_q <= {1'b1, ~^tx_byte, tx_byte};
                        state_q <= TX_INHIBIT;
                    end
                end
                TX_INHIBIT: begin
                    if (cnt_q == CW'(INHIBIT_CYC - 1)) begin
                        cnt_q   <= '0;
                        state_q <= TX_REQ;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_REQ: begin
                    dbit_q  <= 1'b0;
                    idx_q   <= '0;
                    cnt_q   <= '0;
                    state_q <= TX_SHIFT;
                end
                TX_SHIFT: begin
                    if (timed_out) begin
                        tx_err  <= 1'b1;
                        dbit_q  <= 1'b1;
                        state_q <= TX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (bit_fall) begin
                            dbit_q <= frame_q[idx_q];
                            idx_q  <= idx_q + 1'b1;
                            if (idx_q == 4'(FRAME_W - 1)) state_q <= TX_ACK;
                        end
                    end
                end
                TX_ACK: begin
                    if (timed_out) begin
                        tx_err  <= 1'b1;
                        state_q <= TX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (bit_fall) begin
                            tx_done <= !bit_val;
                            tx_err  <= bit_val;
                            state_q <= TX_IDLE;
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ps2_host_port.sv
// PS/2 host port top: line filtering, edge detection, transmit and
// receive engines, and an eight-location byte register bank with
// per-event set, clear and mask. Reads are combinational.
module ps2_host_port
    import ps2_pkg::*;
#(
    parameter int INHIBIT_CYC = 25000,
    parameter int FILT_LEN    = 8,
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [BYTE_W-1:0] reg_wr_data,
    input  logic              reg_rd_en,
    output logic [BYTE_W-1:0] reg_rd_data,
    input  logic              ps2_clk_in,
    input  logic              ps2_data_in,
    output logic              ps2_clk_pd,
    output logic              ps2_data_pd,
    output logic              irq
);
    logic [1:0]        raw_lines;
    logic [1:0]        clean_lines;
    logic              clk_clean_q;
    logic              clk_fall;

    logic [BYTE_W-1:0] txd_q;
    logic [BYTE_W-1:0] rxd_q;
    logic [EV_W-1:0]   status_q;
    logic [EV_W-1:0]   mask_q;
    logic [EV_W-1:0]   hw_ev;
    logic [EV_W-1:0]   set_bits;
    logic [EV_W-1:0]   clr_bits;

    logic              tx_start, tx_busy, tx_done, tx_err;
    logic              rx_done, rx_err;
    logic [BYTE_W-1:0] rx_byte;

    assign raw_lines = {ps2_data_in, ps2_clk_in};

    // One filter per line: index 0 is clock, index 1 is data.
    for (genvar g = 0; g < 2; g++) begin : g_line
        ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_in    (raw_lines[g]),
            .line_clean (clean_lines[g])
        );
    end

    // Remember the last filtered clock level for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_clean_q <= 1'b1;
        else        clk_clean_q <= clean_lines[0];
    end
    assign clk_fall = clk_clean_q && !clean_lines[0];

    assign tx_start = reg_wr_en && (reg_addr == A_TXD) && !tx_busy;

    ps2_tx_fsm #(.INHIBIT_CYC(INHIBIT_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_start (tx_start),
        .tx_byte  (reg_wr_data),
        .bit_fall (clk_fall),
        .bit_val  (clean_lines[1]),
        .tx_busy  (tx_busy),
        .clk_pd   (ps2_clk_pd),
        .data_pd  (ps2_data_pd),
        .tx_done  (tx_done),
        .tx_err   (tx_err)
    );

    ps2_rx_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_enable (!tx_busy),
        .bit_fall  (clk_fall),
        .bit_val   (clean_lines[1]),
        .rx_done   (rx_done),
        .rx_err    (rx_err),
        .rx_byte   (rx_byte)
    );

    assign hw_ev    = {rx_err, rx_done, tx_err, tx_done};
    assign set_bits = (reg_wr_en && reg_addr == A_SET) ? reg_wr_data[EV_W-1:0] : '0;
    assign clr_bits = (reg_wr_en && reg_addr == A_CLR) ? reg_wr_data[EV_W-1:0] : '0;

    // Event bits: clears apply first, hardware and software sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | hw_ev | set_bits;
    end

    // Mask, transmit byte and receive byte holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            txd_q  <= '0;
            rxd_q  <= '0;
        end else begin
            if (reg_wr_en && reg_addr == A_MASK) mask_q <= reg_wr_data[EV_W-1:0];
            if (tx_start) txd_q <= reg_wr_data;
            if (rx_done)  rxd_q <= rx_byte;
        end
    end

    assign irq = |(status_q & ~mask_q);

    // Read multiplexer.
    always_comb begin
        reg_rd_data = '0;
        if (reg_rd_en) begin
            case (reg_addr)
                A_TXD:   reg_rd_data = txd_q;
                A_RXD:   reg_rd_data = rxd_q;
                A_STAT:  reg_rd_data = {3'b000, tx_busy, status_q};
                A_MASK:  reg_rd_data = {4'b0000, mask_q};
                A_PEND:  reg_rd_data = {4'b0000, status_q & ~mask_q};
                default: reg_rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/ps2_host_port_chk.sv
// Property checker for the PS/2 host port, bound to the top module.
// Observes line drive, event bits and register writes.
module ps2_host_port_chk #(
    parameter int INHIBIT_CYC = 25000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_pd,
    input logic       data_pd,
    input logic       tx_busy,
    input logic       tx_done,
    input logic       rx_done,
    input logic [3:0] status,
    input logic [3:0] mask,
    input logic       irq,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wr_data,
    input logic [7:0] txd
);
    int unsigned hold_cnt;

    // Count consecutive cycles of clock pull-down.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_cnt <= 0;
        else if (clk_pd) hold_cnt <= hold_cnt + 1;
        else             hold_cnt <= 0;
    end

    p_inhibit_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_pd) |-> hold_cnt >= INHIBIT_CYC);

    p_data_under_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_pd) && clk_pd) |-> $past(clk_pd));

    p_drive_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_pd || data_pd) |-> tx_busy);

    p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && wr_en && addr == 3'd0) |=> $stable(txd));

    p_ready_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> $past(rx_done || (wr_en && addr == 3'd3 && wr_data[2])));

    p_clear_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4 && wr_data[0] && !tx_done) |=> !status[0]);

    p_all_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 4'hF) |-> !irq);
endmodule

bind ps2_host_port ps2_host_port_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_pd  (ps2_clk_pd),
    .data_pd (ps2_data_pd),
    .tx_busy (tx_busy),
    .tx_done (tx_done),
    .rx_done (rx_done),
    .status  (status_q),
    .mask    (mask_q),
    .irq     (irq),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wr_data (reg_wr_data),
    .txd     (txd_q)
);

// File: tb/sim_ps2_host_port.sv
// Directed bench: one task per scenario, with an open-collector
// device model on both lines.
module sim_ps2_host_port;
    localparam int INH  = 40;
    localparam int FLT  = 3;
    localparam int TMO  = 3000;
    localparam int HALF = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       dev_clk_pd = 1'b0;
    logic       dev_data_pd = 1'b0;
    logic       host_clk_pd, host_data_pd, irq;
    logic       clk_line, data_line;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign clk_line  = ~(host_clk_pd | dev_clk_pd);
    assign data_line = ~(host_data_pd | dev_data_pd);

    ps2_host_port #(.INHIBIT_CYC(INH), .FILT_LEN(FLT), .TIMEOUT_CYC(TMO)) u0 (
        .clk (clk), .rst_n (rst_n),
        .reg_addr (addr), .reg_wr_en (wr_en), .reg_wr_data (wdata),
        .reg_rd_en (rd_en), .reg_rd_data (rdata),
        .ps2_clk_in (clk_line), .ps2_data_in (data_line),
        .ps2_clk_pd (host_clk_pd), .ps2_data_pd (host_data_pd),
        .irq (irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Device side of a host-to-device transfer; bits[9:0] = d0..d7, parity, stop.
    task automatic dev_capture(input bit give_ack, output logic [9:0] bits,
                               output int hold, output bit start_low);
        hold = 0;
        bits = '0;
        @(negedge clk);
        while (!host_clk_pd) @(negedge clk);
        while (host_clk_pd) begin hold++; @(negedge clk); end
        start_low = !data_line;
        wait_cyc(10);
        for (int i = 1; i <= 11; i++) begin
            if (i == 11 && give_ack) dev_data_pd = 1'b1;
            wait_cyc(HALF);
            dev_clk_pd = 1'b1;
            wait_cyc(HALF);
            dev_clk_pd = 1'b0;
            if (i <= 10) bits[i-1] = data_line;
        end
        wait_cyc(HALF);
        dev_data_pd = 1'b0;
        wait_cyc(5);
    endtask

    // Device-to-host frame; nbits limits how many of the 11 bits are sent.
    task automatic dev_send(input logic [7:0] b, input bit bad_par, input bit bad_stop, input int nbits);
        logic [10:0] fr;
        fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < nbits; i++) begin
            dev_data_pd = ~fr[i];
            wait_cyc(HALF);
            dev_clk_pd = 1'b1;
            wait_cyc(HALF);
            dev_clk_pd = 1'b0;
        end
        dev_data_pd = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1", "clk pull-down", host_clk_pd, 0);
        check("R1", "data pull-down", host_data_pd, 0);
        check("R1", "irq", irq, 0);
        reg_rd(3'd2, v); check("R1", "status", v, 8'h00);
        reg_rd(3'd5, v); check("R1", "mask", v, 8'h0F);
    endtask

    task automatic t_tx_ok(input logic [7:0] b);
        logic [9:0] bits; int hold; bit sl; logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        reg_wr(3'd0, b);
        dev_capture(1'b1, bits, hold, sl);
        check("R2", "inhibit >= INH", int'(hold >= INH), 1);
        check("R2", "start bit low at release", sl, 1);
        check("R3", "data bits", bits[7:0], b);
        check("R3", "odd parity", bits[8], ~^b);
        check("R3", "stop bit", bits[9], 1);
        reg_rd(3'd2, v);
        check("R4", "status after ack", v, 8'h01);
    endtask

    task automatic t_tx_noack();
        logic [9:0] bits; int hold; bit sl; logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        reg_wr(3'd0, 8'h81);
        dev_capture(1'b0, bits, hold, sl);
        reg_rd(3'd2, v);
        check("R4", "status with no ack", v, 8'h02);
    endtask

    task automatic t_tx_timeout();
        logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        reg_wr(3'd0, 8'h33);
        @(negedge clk);
        while (!host_clk_pd) @(negedge clk);
        while (host_clk_pd) @(negedge clk);
        wait_cyc(TMO - 100);
        reg_rd(3'd2, v);
        check("R5", "still busy before timeout", v, 8'h10);
        wait_cyc(200);
        reg_rd(3'd2, v);
        check("R5", "error after timeout, idle", v, 8'h02);
    endtask

    task automatic t_busy_ignore();
        logic [9:0] bits; int hold; bit sl; logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        reg_wr(3'd0, 8'hA5);
        reg_wr(3'd0, 8'h3C);
        reg_rd(3'd2, v);
        check("R6", "busy bit", v[4], 1);
        reg_rd(3'd0, v);
        check("R6", "tx byte kept", v, 8'hA5);
        dev_capture(1'b1, bits, hold, sl);
        check("R6", "byte sent", bits[7:0], 8'hA5);
    endtask

    task automatic t_rx_ok(input logic [7:0] b);
        logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        dev_send(b, 1'b0, 1'b0, 11);
        reg_rd(3'd1, v); check("R7", "rx byte", v, b);
        reg_rd(3'd2, v); check("R7", "rx ready", v, 8'h04);
    endtask

    task automatic t_rx_bad(input bit bad_par, input bit bad_stop, input logic [7:0] prev);
        logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        dev_send(8'h96, bad_par, bad_stop, 11);
        reg_rd(3'd2, v); check("R8", "rx error status", v, 8'h08);
        reg_rd(3'd1, v); check("R8", "rx byte unchanged", v, prev);
    endtask

    task automatic t_rx_timeout();
        logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        dev_send(8'h12, 1'b0, 1'b0, 4);
        wait_cyc(TMO + 100);
        reg_rd(3'd2, v); check("R9", "rx timeout", v, 8'h08);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        dev_data_pd = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_cyc(10);
            dev_clk_pd = 1'b1;
            wait_cyc(FLT - 1);
            dev_clk_pd = 1'b0;
        end
        wait_cyc(10);
        dev_data_pd = 1'b0;
        wait_cyc(TMO + 100);
        reg_rd(3'd2, v); check("R12", "no frame from glitches", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        reg_wr(3'd4, 8'h0F);
        reg_wr(3'd3, 8'h05);
        reg_rd(3'd2, v); check("R10", "set register", v, 8'h05);
        check("R11", "irq while masked", irq, 0);
        reg_wr(3'd5, 8'h0B);
        reg_rd(3'd5, v); check("R10", "mask readback", v, 8'h0B);
        check("R11", "irq unmasked", irq, 1);
        reg_rd(3'd6, v); check("R11", "pending", v, 8'h04);
        reg_wr(3'd4, 8'h04);
        check("R11", "irq after clear", irq, 0);
        reg_rd(3'd2, v); check("R10", "clear register", v, 8'h01);
        reg_wr(3'd5, 8'h0F);
        reg_wr(3'd4, 8'h0F);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_tx_ok(8'h5A);
        t_tx_ok(8'h01);
        t_tx_noack();
        t_tx_timeout();
        t_busy_ignore();
        t_rx_ok(8'hC3);
        t_rx_ok(8'h5A);
        t_rx_bad(1'b1, 1'b0, 8'h5A);
        t_rx_bad(1'b0, 1'b1, 8'h5A);
        t_rx_timeout();
        t_glitch();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule